// File: doc/BRIEF.md
# Two-Group Keypad Select Register

This block presents eight push buttons to software through one byte-wide register. The buttons form two groups of four. Software writes two active-low select bits to choose which groups are visible. It then reads the chosen buttons back in the low nibble, where a pressed button reads as 0. When both groups are selected, their lines are combined, so a 0 in the nibble means the button at that position is pressed in at least one chosen group. The top bits always read as 1.

Button levels arrive on an 8-bit input, one bit per button, with 1 meaning pressed. The register is recomputed whenever that input differs from its last sampled value, and also whenever software writes the register. A recompute that turns any nibble bit from 1 to 0 sends a one-cycle pulse toward an edge-triggered interrupt latch. Debouncing of the switches is the job of logic outside this block.

Top module: `kp_select_reg`

## Requirements
- R1: After reset, `rd_data` reads 0xFF and `irq_pulse` is 0.
- R2: Bits 7 and 6 of `rd_data` read as 1 whatever value is written.
- R3: A write stores `wr_data[5:4]` as the select bits, which read back at `rd_data[5:4]`. `wr_data[7:6]` and `wr_data[3:0]` have no effect.
- R4: Select bit 4 at 0 makes buttons 3..0 visible. Select bit 5 at 0 makes buttons 7..4 visible. With both at 0 the two groups are ORed position by position. With both at 1 no button is visible and the nibble reads 0xF.
- R5: The nibble is the inverse of the combined visible lines, so a pressed button reads 0 at position (button index mod 4).
- R6: `rd_data` takes its new value one clock edge after a write, or after the edge where `btn_state` first shows a new value.
- R7: `irq_pulse` is 1 for the cycle in which `rd_data` takes a value where some nibble bit fell from 1 to 0. It is 0 in every other cycle.
- R8: With no write and `btn_state` unchanged since the previous edge, `rd_data` holds its value and `irq_pulse` stays 0.
- R9: A write that makes an already-pressed button visible raises `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_state | input | 8 | Button levels, 1 = pressed; bit i is button i |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; only bits 5:4 are stored |
| rd_data | output | 8 | Register value |
| irq_pulse | output | 1 | One-cycle pulse on any nibble fall |

## Verification
The bench builds the block with its default parameters: 4 buttons per group, 2 groups and an 8-bit register. This keeps the full button space of 256 patterns and all four select codes small enough for random stimulus to cover repeatedly. Directed steps cover selection of each group alone, of both groups and of none. They also cover a hidden press that is later revealed by a write, and the quiet cycle that follows a refresh.

// File: rtl/kp_pkg.sv
package kp_pkg;
   // Level of an active-low group select bit
   typedef enum logic {
      SEL_ON  = 1'b0,
      SEL_OFF = 1'b1
   } sel_lvl_e;
endpackage

// File: rtl/kp_group_mux.sv
module kp_group_mux
   import kp_pkg::*;
#(
   parameter int GROUP_W    = 4,
   parameter int NUM_GROUPS = 2,
   localparam int BTN_W     = GROUP_W * NUM_GROUPS
) (
   input  logic [BTN_W-1:0]      btn,
   input  logic [NUM_GROUPS-1:0] sel_n,
   output logic [GROUP_W-1:0]    nib_n
);
   logic [GROUP_W-1:0] masked [NUM_GROUPS];

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign masked[g] = (sel_lvl_e'(sel_n[g]) == SEL_ON) ?
                         btn[g*GROUP_W +: GROUP_W] : '0;
   end

   always_comb begin
      logic [GROUP_W-1:0] acc;
      acc = '0;
      for (int g = 0; g < NUM_GROUPS; g++) acc = acc | masked[g];
      nib_n = ~acc;
   end
endmodule

// File: rtl/kp_change_det.sv
module kp_change_det #(
   parameter int BTN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BTN_W-1:0] btn_state,
   output logic             changed
);
   logic [BTN_W-1:0] btn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) btn_q <= '0;
      else        btn_q <= btn_state;
   end

   assign changed = (btn_state != btn_q);
endmodule

// File: rtl/kp_fall_det.sv
module kp_fall_det #(
   parameter int GROUP_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               refresh,
   input  logic [GROUP_W-1:0] old_nib,
   input  logic [GROUP_W-1:0] new_nib,
   output logic               irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= refresh && ((old_nib & ~new_nib) != '0);
   end
endmodule

// File: rtl/kp_select_reg.sv
module kp_select_reg #(
   parameter int GROUP_W    = 4,
   parameter int NUM_GROUPS = 2,
   parameter int REG_W      = 8,
   localparam int BTN_W     = GROUP_W * NUM_GROUPS,
   localparam int SEL_LO    = GROUP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BTN_W-1:0] btn_state,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             irq_pulse
);
   if (GROUP_W < 1 || NUM_GROUPS < 1) begin : g_bad_shape
      $error("kp_select_reg: group width and count must be positive");
   end
   if (REG_W <= GROUP_W + NUM_GROUPS) begin : g_bad_width
      $error("kp_select_reg: register needs at least one fixed upper bit");
   end

   logic [NUM_GROUPS-1:0] sel_q, sel_d;
   logic [GROUP_W-1:0]    nib_q, nib_d;
   logic                  btn_changed, refresh;

   kp_change_det #(.BTN_W(BTN_W)) u_chg (
      .clk       (clk),
      .rst_n     (rst_n),
      .btn_state (btn_state),
      .changed   (btn_changed)
   );

   assign refresh = wr_en | btn_changed;
   assign sel_d   = wr_en ? wr_data[SEL_LO +: NUM_GROUPS] : sel_q;

   kp_group_mux #(.GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS)) u_mux (
      .btn   (btn_state),
      .sel_n (sel_d),
      .nib_n (nib_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '1;
         nib_q <= '1;
      end else if (refresh) begin
         sel_q <= sel_d;
         nib_q <= nib_d;
      end
   end

   kp_fall_det #(.GROUP_W(GROUP_W)) u_fall (
      .clk     (clk),
      .rst_n   (rst_n),
      .refresh (refresh),
      .old_nib (nib_q),
      .new_nib (nib_d),
      .irq     (irq_pulse)
   );

   always_comb begin
      rd_data = '1;
      rd_data[GROUP_W-1:0]          = nib_q;
      rd_data[SEL_LO +: NUM_GROUPS] = sel_q;
   end
endmodule

// File: rtl/kp_select_reg_chk.sv
module kp_select_reg_chk #(
   parameter int GROUP_W    = 4,
   parameter int NUM_GROUPS = 2,
   parameter int REG_W      = 8,
   localparam int BTN_W     = GROUP_W * NUM_GROUPS,
   localparam int SEL_LO    = GROUP_W,
   localparam int UP_LO     = GROUP_W + NUM_GROUPS
) (
   input logic             clk,
   input logic             rst_n,
   input logic [BTN_W-1:0] btn_state,
   input logic             wr_en,
   input logic [REG_W-1:0] wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             irq_pulse
);
   // R2
   upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      &rd_data[REG_W-1:UP_LO]);

   // R3
   sel_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data[SEL_LO +: NUM_GROUPS] == $past(wr_data[SEL_LO +: NUM_GROUPS]));

   // R7
   irq_needs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (($past(rd_data[GROUP_W-1:0]) & ~rd_data[GROUP_W-1:0]) != '0));

   // R7
   fall_gives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rd_data[GROUP_W-1:0]) & ~rd_data[GROUP_W-1:0]) != '0) |-> irq_pulse);

   // R8
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && $stable(btn_state)) |=> ($stable(rd_data) && !irq_pulse));
endmodule

bind kp_select_reg kp_select_reg_chk #(
   .GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS), .REG_W(REG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .btn_state(btn_state), .wr_en(wr_en),
   .wr_data(wr_data), .rd_data(rd_data), .irq_pulse(irq_pulse)
);

// File: tb/sim_kp_select_reg.sv
module sim_kp_select_reg;
   localparam int CLK_NS = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] btn_state = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model state
   logic [1:0] m_sel;
   logic [3:0] m_nib;
   logic [7:0] m_btn;
   logic       m_irq;

   always #(CLK_NS/2) clk = ~clk;

   kp_select_reg u0 (
      .clk(clk), .rst_n(rst_n), .btn_state(btn_state), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .irq_pulse(irq_pulse)
   );

   function automatic logic [3:0] exp_nib(logic [7:0] b, logic [1:0] s);
      logic [3:0] v;
      v = 4'h0;
      if (!s[0]) v = v | b[3:0];
      if (!s[1]) v = v | b[7:4];
      return ~v;
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // Drive one cycle of stimulus at a falling edge, sample after the next rise.
   task automatic step(logic wr, logic [7:0] d, logic [7:0] b, string req);
      logic [3:0] n;
      wr_en = wr; wr_data = d; btn_state = b;
      if (wr || b != m_btn) begin
         logic [1:0] s;
         s = wr ? d[5:4] : m_sel;
         n = exp_nib(b, s);
         m_irq = (m_nib & ~n) != 4'h0;
         m_nib = n;
         m_sel = s;
      end else begin
         m_irq = 1'b0;
      end
      m_btn = b;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      check(req, rd_data, {2'b11, m_sel, m_nib});
      check(req, {7'd0, irq_pulse}, {7'd0, m_irq});
   endtask

   initial begin
      m_sel = 2'b11; m_nib = 4'hF; m_btn = 8'h00; m_irq = 1'b0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1", rd_data, 8'hFF);
      check("R1", {7'd0, irq_pulse}, 8'h00);

      // R2 R3: upper and low write bits dropped, both groups on
      step(1'b1, 8'h00, 8'h00, "R2/R3");
      check("R2", rd_data, 8'hCF);
      // R3: group 0 only, low nibble of write ignored
      step(1'b1, 8'h2A, 8'h00, "R3");
      check("R3", rd_data, 8'hEF);
      // R5 R6 R7: press button 2
      step(1'b0, 8'h00, 8'h04, "R5/R7");
      check("R5", rd_data, 8'hEB);
      check("R7", {7'd0, irq_pulse}, 8'h01);
      // R8: held level, no irq
      step(1'b0, 8'h00, 8'h04, "R8");
      check("R8", {7'd0, irq_pulse}, 8'h00);
      // R4: hidden group 1 press
      step(1'b0, 8'h00, 8'h40, "R4");
      check("R4", rd_data, 8'hEF);
      // R9: select reveals held button 6
      step(1'b1, 8'h10, 8'h40, "R9");
      check("R9", rd_data, 8'hDB);
      check("R9", {7'd0, irq_pulse}, 8'h01);
      // R4: both groups ORed
      step(1'b1, 8'h00, 8'h41, "R4");
      check("R4", rd_data, 8'hCA);
      // R4: neither group
      step(1'b1, 8'h30, 8'h41, "R4");
      check("R4", rd_data, 8'hFF);

      // random mix, R4 R6 R7 R8
      for (int i = 0; i < 600; i++) begin
         logic       w;
         logic [7:0] b;
         w = ($urandom % 4) == 0;
         b = (($urandom % 3) == 0) ? 8'($urandom) : m_btn;
         step(w, 8'($urandom), b, "R4/R6/R7/R8");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule